// File: doc/BRIEF.md
# UART to I2C Bridge Converter

This block turns command packets arriving as serial characters on a control channel into transactions on a two-wire I2C bus, acting as the only master on that bus. A packet opens with a sync character, followed by a device byte (7-bit peripheral address above a direction bit), a register byte, a byte count and, for writes, the payload. The bridge stores the whole packet before it touches the bus. It then plays out the matching I2C write, or a register-addressed read, and sends the answer back over the serial line. A write is answered with one acknowledge character. A read is answered with the bytes it fetched, then the acknowledge character.

A static mode input removes the register byte from the bus transaction. This suits peripherals that take a single command byte instead of a register pointer. Serial frames with a bad parity or stop bit, packets with an unusable count and packets that do not open with the sync character never reach the bus. If the peripheral refuses any byte, the transaction ends at once with STOP and the serial side stays silent.

Top module: `uart_i2c_bridge`

## Requirements
- R1: Each serial character, in either direction, is an 11-bit frame: one low start bit, 8 data bits LSB first, one even-parity bit (data plus parity hold an even number of ones) and one high stop bit. Every bit lasts CLKS_PER_BIT clock cycles.
- R2: A packet starts only with the sync character 0x79. Any other character received while waiting for a sync is discarded and produces no bus or serial activity.
- R3: A received frame with a parity or stop-bit error, anywhere from the device byte through the last payload byte, aborts the packet. No I2C traffic and no reply follow.
- R4: A count byte of 0 or greater than MAX_BYTES aborts the packet with no I2C traffic and no reply. A count of exactly MAX_BYTES is accepted.
- R5: A write packet (device byte bit 0 = 0) in register mode (cmd_only = 0) produces START, the device byte, the register byte, each payload byte in order, then STOP. Each byte is followed by a peripheral ACK clock. The bridge then sends the acknowledge character 0xC3.
- R6: A read packet (device byte bit 0 = 1) in register mode produces START, the device byte with bit 0 cleared, the register byte, a repeated START, then the device byte as received. Count bytes are then read, with the master sending ACK (SDA low) after each byte except the last, which gets NACK (SDA high). STOP follows. The bridge then sends the bytes read, in order, followed by 0xC3.
- R7: With cmd_only = 1 the register byte is omitted. The device byte is sent as received right after START, followed directly by the payload bytes (write) or by the bytes read (read). There is no repeated START.
- R8: If the peripheral leaves SDA high in the acknowledge slot of any byte the master sends, the master issues STOP next, sends no further bytes and sends no serial reply.
- R9: SDA changes only while SCL is low, except for the falling edge of START and the rising edge of STOP. Every SCL high phase lasts 2*QTR_CLKS cycles.
- R10: After reset, SCL, SDA and the serial output are all high. SCL and SDA are high again after every STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| uart_rxd | input | 1 | Serial command input, idle high |
| uart_txd | output | 1 | Serial reply output, idle high |
| cmd_only | input | 1 | 1 = omit the register byte on the bus; static during a packet |
| scl_out | output | 1 | I2C clock; 0 = pull low, 1 = release |
| sda_out | output | 1 | I2C data drive; 0 = pull low, 1 = release |
| sda_in | input | 1 | Resolved I2C data line |

## Verification
The bench attaches a behavioral peripheral that decodes START, STOP, every byte and every acknowledge slot. It compares that event list and the decoded reply characters with sequences built from the requirements. A register write, a register read and both directions in command-only mode are run. These show whether the register byte, the repeated START and the master's final NACK are present or missing. Bad first characters, parity and stop errors at different packet positions, counts of 0, MAX_BYTES and MAX_BYTES+1, and a refused register byte check that every abort path stays silent on both sides. The SCL high width is measured on every clock pulse.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam logic [7:0] SYNC_CHAR = 8'h79;
    localparam logic [7:0] ACK_CHAR  = 8'hC3;
    localparam int         FRAME_BITS = 11;

    typedef enum logic [1:0] {
        I2C_START,
        I2C_STOP,
        I2C_XFER
    } i2c_op_e;

    typedef enum logic [3:0] {
        ST_SYNC, ST_DEV, ST_REG, ST_CNT, ST_WDAT,
        ST_START, ST_DEVA, ST_REGA, ST_RSTART, ST_DEVR,
        ST_WR, ST_RD, ST_STOP,
        ST_TXD, ST_TXACK
    } bstate_e;

    function automatic logic even_par(input logic [7:0] b);
        return ^b;
    endfunction

endpackage

// File: rtl/br_uart_rx.sv
module br_uart_rx #(
    parameter int CLKS_PER_BIT = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rxd,
    output logic       valid,
    output logic [7:0] data,
    output logic       err
);
    import bridge_pkg::*;
    localparam int CW   = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam int HALF = CLKS_PER_BIT / 2;

    logic          s1_q, s2_q, act_q, valid_q;
    logic [CW-1:0] cnt_q;
    logic [3:0]    bitn_q;
    logic [9:0]    sh_q;

    always_ff @(posedge clk) begin
        valid_q <= 1'b0;
        if (rst) begin
            s1_q   <= 1'b1;
            s2_q   <= 1'b1;
            act_q  <= 1'b0;
            cnt_q  <= '0;
            bitn_q <= '0;
            sh_q   <= '0;
        end else begin
            s1_q <= rxd;
            s2_q <= s1_q;
            if (!act_q) begin
                if (!s2_q) begin
                    act_q  <= 1'b1;
                    cnt_q  <= CW'(HALF);
                    bitn_q <= '0;
                end
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end else begin
                cnt_q <= CW'(CLKS_PER_BIT - 1);
                if (bitn_q == 4'd0) begin
                    if (s2_q) act_q <= 1'b0;
                    else      bitn_q <= 4'd1;
                end else begin
                    sh_q <= {s2_q, sh_q[9:1]};
                    if (bitn_q == 4'(FRAME_BITS - 1)) begin
                        act_q   <= 1'b0;
                        valid_q <= 1'b1;
                    end else begin
                        bitn_q <= bitn_q + 1'b1;
                    end
                end
            end
        end
    end

    assign valid = valid_q;
    assign data  = sh_q[7:0];
    assign err   = (even_par(sh_q[7:0]) != sh_q[8]) || !sh_q[9];

endmodule

// File: rtl/br_uart_tx.sv
module br_uart_tx #(
    parameter int CLKS_PER_BIT = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       send,
    input  logic [7:0] data,
    output logic       busy,
    output logic       done,
    output logic       txd
);
    import bridge_pkg::*;
    localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;

    logic          busy_q, done_q, txd_q;
    logic [CW-1:0] cnt_q;
    logic [3:0]    bitn_q;
    logic [9:0]    sh_q;

    always_ff @(posedge clk) begin
        done_q <= 1'b0;
        if (rst) begin
            busy_q <= 1'b0;
            txd_q  <= 1'b1;
            cnt_q  <= '0;
            bitn_q <= '0;
            sh_q   <= '1;
        end else if (!busy_q) begin
            txd_q <= 1'b1;
            if (send) begin
                sh_q   <= {1'b1, even_par(data), data};
                txd_q  <= 1'b0;
                busy_q <= 1'b1;
                cnt_q  <= CW'(CLKS_PER_BIT - 1);
                bitn_q <= '0;
            end
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else begin
            cnt_q <= CW'(CLKS_PER_BIT - 1);
            if (bitn_q == 4'(FRAME_BITS - 1)) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
            end else begin
                txd_q  <= sh_q[0];
                sh_q   <= {1'b1, sh_q[9:1]};
                bitn_q <= bitn_q + 1'b1;
            end
        end
    end

    assign busy = busy_q;
    assign done = done_q;
    assign txd  = txd_q;

    p_tx_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> txd_q);

endmodule

// File: rtl/br_i2c_engine.sv
module br_i2c_engine #(
    parameter int QTR_CLKS = 25
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    input  bridge_pkg::i2c_op_e  cmd_op,
    input  logic [8:0]           cmd_bits,
    output logic                 busy,
    output logic                 done,
    output logic [8:0]           rx_bits,
    output logic                 scl_out,
    output logic                 sda_out,
    input  logic                 sda_in
);
    import bridge_pkg::*;
    localparam int TW = (QTR_CLKS > 1) ? $clog2(QTR_CLKS) : 1;

    i2c_op_e       op_q;
    logic          busy_q, done_q, scl_q, sda_q;
    logic [TW-1:0] tmr_q;
    logic [1:0]    qtr_q;
    logic [3:0]    bitn_q;
    logic [8:0]    sh_q, rx_q;

    always_ff @(posedge clk) begin
        done_q <= 1'b0;
        if (rst) begin
            op_q   <= I2C_STOP;
            busy_q <= 1'b0;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            tmr_q  <= '0;
            qtr_q  <= '0;
            bitn_q <= '0;
            sh_q   <= '0;
            rx_q   <= '0;
        end else if (!busy_q) begin
            if (cmd_valid) begin
                op_q   <= cmd_op;
                sh_q   <= cmd_bits;
                busy_q <= 1'b1;
                tmr_q  <= TW'(QTR_CLKS - 1);
                qtr_q  <= '0;
                bitn_q <= '0;
            end
        end else if (tmr_q != '0) begin
            tmr_q <= tmr_q - 1'b1;
        end else begin
            tmr_q <= TW'(QTR_CLKS - 1);
            qtr_q <= qtr_q + 1'b1;
            case (qtr_q)
                2'd0: sda_q <= (op_q == I2C_START) ? 1'b1 :
                               (op_q == I2C_STOP)  ? 1'b0 : sh_q[8];
                2'd1: scl_q <= 1'b1;
                2'd2: begin
                    if (op_q == I2C_START)     sda_q <= 1'b0;
                    else if (op_q == I2C_STOP) sda_q <= 1'b1;
                    else                       rx_q  <= {rx_q[7:0], sda_in};
                end
                default: begin
                    if (op_q != I2C_STOP) scl_q <= 1'b0;
                    if (op_q == I2C_XFER && bitn_q != 4'd8) begin
                        sh_q   <= {sh_q[7:0], 1'b0};
                        bitn_q <= bitn_q + 1'b1;
                    end else begin
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_bits = rx_q;
    assign scl_out = scl_q;
    assign sda_out = sda_q;

    // R9: data moves under a high clock only for START or STOP
    p_sda_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (scl_q && $past(scl_q) && (sda_q != $past(sda_q))) |-> (op_q != I2C_XFER));

    // R10: bus released once a STOP has finished
    p_bus_released_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && op_q == I2C_STOP) |-> (scl_q && sda_q));

endmodule

// File: rtl/uart_i2c_bridge.sv
module uart_i2c_bridge #(
    parameter int CLKS_PER_BIT = 100,
    parameter int QTR_CLKS     = 25,
    parameter int MAX_BYTES    = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic uart_rxd,
    output logic uart_txd,
    input  logic cmd_only,
    output logic scl_out,
    output logic sda_out,
    input  logic sda_in
);
    import bridge_pkg::*;
    localparam int         IW    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
    localparam logic [7:0] MAXB8 = 8'(MAX_BYTES);

    logic       rx_valid, rx_err, tx_busy, tx_done, tx_send;
    logic [7:0] rx_data, tx_byte;
    logic       eng_valid, eng_busy, eng_done;
    i2c_op_e    eng_op;
    logic [8:0] eng_bits, eng_rx;

    bstate_e       state_q;
    logic [7:0]    dev_q, reg_q, cnt_q;
    logic [IW-1:0] idx_q;
    logic          issued_q, nack_q, mode_q;
    logic [7:0]    buf_q [MAX_BYTES];

    wire is_rd    = dev_q[0];
    wire last     = (8'(idx_q) == cnt_q - 8'd1);
    wire bus_ph   = (state_q >= ST_START) && (state_q <= ST_STOP);
    wire tx_ph    = (state_q == ST_TXD) || (state_q == ST_TXACK);
    wire peer_nak = eng_rx[0];

    br_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk(clk), .rst(rst), .rxd(uart_rxd),
        .valid(rx_valid), .data(rx_data), .err(rx_err));

    br_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk(clk), .rst(rst), .send(tx_send), .data(tx_byte),
        .busy(tx_busy), .done(tx_done), .txd(uart_txd));

    br_i2c_engine #(.QTR_CLKS(QTR_CLKS)) u_eng (
        .clk(clk), .rst(rst), .cmd_valid(eng_valid), .cmd_op(eng_op),
        .cmd_bits(eng_bits), .busy(eng_busy), .done(eng_done),
        .rx_bits(eng_rx), .scl_out(scl_out), .sda_out(sda_out), .sda_in(sda_in));

    always_comb begin
        eng_op   = I2C_XFER;
        eng_bits = {dev_q, 1'b1};
        case (state_q)
            ST_START, ST_RSTART: eng_op = I2C_START;
            ST_STOP:             eng_op = I2C_STOP;
            ST_DEVA:  eng_bits = {(mode_q ? dev_q : {dev_q[7:1], 1'b0}), 1'b1};
            ST_REGA:  eng_bits = {reg_q, 1'b1};
            ST_WR:    eng_bits = {buf_q[idx_q], 1'b1};
            ST_RD:    eng_bits = {8'hFF, last};
            default:  eng_bits = {dev_q, 1'b1};
        endcase
    end

    assign eng_valid = bus_ph && !issued_q && !eng_busy;
    assign tx_send   = tx_ph && !issued_q && !tx_busy;
    assign tx_byte   = (state_q == ST_TXACK) ? ACK_CHAR : buf_q[idx_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_SYNC;
            dev_q    <= '0;
            reg_q    <= '0;
            cnt_q    <= '0;
            idx_q    <= '0;
            issued_q <= 1'b0;
            nack_q   <= 1'b0;
            mode_q   <= 1'b0;
        end else begin
            if (eng_valid || tx_send) issued_q <= 1'b1;
            if (eng_done || tx_done)  issued_q <= 1'b0;
            case (state_q)
                ST_SYNC: if (rx_valid && !rx_err && rx_data == SYNC_CHAR) state_q <= ST_DEV;
                ST_DEV, ST_REG, ST_CNT, ST_WDAT: if (rx_valid) begin
                    if (rx_err) state_q <= ST_SYNC;
                    else case (state_q)
                        ST_DEV: begin dev_q <= rx_data; state_q <= ST_REG; end
                        ST_REG: begin reg_q <= rx_data; state_q <= ST_CNT; end
                        ST_CNT: begin
                            cnt_q  <= rx_data;
                            idx_q  <= '0;
                            nack_q <= 1'b0;
                            mode_q <= cmd_only;
                            if (rx_data == 8'd0 || rx_data > MAXB8) state_q <= ST_SYNC;
                            else state_q <= is_rd ? ST_START : ST_WDAT;
                        end
                        default: begin
                            buf_q[idx_q] <= rx_data;
                            if (last) begin idx_q <= '0; state_q <= ST_START; end
                            else idx_q <= idx_q + 1'b1;
                        end
                    endcase
                end
                ST_START:  if (eng_done) state_q <= ST_DEVA;
                ST_RSTART: if (eng_done) state_q <= ST_DEVR;
                ST_DEVA, ST_REGA, ST_DEVR: if (eng_done) begin
                    if (peer_nak) begin nack_q <= 1'b1; state_q <= ST_STOP; end
                    else if (state_q == ST_DEVA && !mode_q) state_q <= ST_REGA;
                    else if (state_q == ST_REGA && is_rd)   state_q <= ST_RSTART;
                    else state_q <= is_rd ? ST_RD : ST_WR;
                end
                ST_WR: if (eng_done) begin
                    if (peer_nak) begin nack_q <= 1'b1; state_q <= ST_STOP; end
                    else if (last) state_q <= ST_STOP;
                    else idx_q <= idx_q + 1'b1;
                end
                ST_RD: if (eng_done) begin
                    buf_q[idx_q] <= eng_rx[8:1];
                    if (last) state_q <= ST_STOP;
                    else idx_q <= idx_q + 1'b1;
                end
                ST_STOP: if (eng_done) begin
                    idx_q   <= '0;
                    state_q <= nack_q ? ST_SYNC : (is_rd ? ST_TXD : ST_TXACK);
                end
                ST_TXD: if (tx_done) begin
                    if (last) state_q <= ST_TXACK;
                    else idx_q <= idx_q + 1'b1;
                end
                default: if (tx_done) state_q <= ST_SYNC;
            endcase
        end
    end

    // R3: while a packet is still arriving the bus engine stays idle
    p_quiet_parse_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q <= ST_WDAT) |-> !eng_busy);

    // R4: only a usable count ever reaches payload collection or the bus
    p_count_range_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q >= ST_WDAT) |-> (cnt_q != 8'd0 && cnt_q <= MAXB8));

endmodule

// File: tb/sim_uart_i2c_bridge.sv
module sim_uart_i2c_bridge;
    localparam int CPB  = 8;
    localparam int QTR  = 4;
    localparam int MAXB = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rxd = 1'b1;
    logic cmd_only = 1'b0;
    logic txd, scl, sda_o;
    logic slow = 1'b0;
    wire  sda_bus = sda_o & ~slow;

    always #5 clk = ~clk;

    uart_i2c_bridge #(.CLKS_PER_BIT(CPB), .QTR_CLKS(QTR), .MAX_BYTES(MAXB)) u0 (
        .clk(clk), .rst(rst), .uart_rxd(rxd), .uart_txd(txd), .cmd_only(cmd_only),
        .scl_out(scl), .sda_out(sda_o), .sda_in(sda_bus));

    int checks = 0, failures = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rdv(input int k);
        return 8'(8'h3C + k * 41);
    endfunction

    // ---------------- behavioral I2C peripheral ----------------
    int evlog [0:255];
    int evn = 0;
    int wcount = 0;
    int nack_at = -1;
    int hi_min = 9999, hi_max = 0;
    logic psc = 1'b1, psd = 1'b1;
    int bitc = -1, k = 0, hrun = 0;
    bit first = 0, goingtx = 0, txm = 0, macked = 0, nak = 0;
    logic [7:0] sh = 0, txb = 0;

    task automatic log_ev(input int v);
        if (evn < 256) evlog[evn] = v;
        evn++;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (scl) hrun++;
            if (scl && psc && psd && !sda_bus) begin
                log_ev(32'h100); bitc = -1; first = 1; txm = 0; goingtx = 0; slow = 0;
            end else if (scl && psc && !psd && sda_bus) begin
                log_ev(32'h101); txm = 0; slow = 0;
            end else if (scl && !psc) begin
                hrun = 1;
                if (bitc >= 0 && bitc < 8 && !txm) sh = {sh[6:0], sda_bus};
                if (bitc == 7 && !txm) begin
                    log_ev({24'b0, sh});
                    nak = (wcount == nack_at);
                    wcount++;
                    if (first) begin goingtx = sh[0] && !nak; first = 0; end
                end
                if (bitc == 8 && txm) begin
                    log_ev(32'h200 | {24'b0, txb});
                    log_ev(32'h300 | {31'b0, sda_bus});
                    macked = !sda_bus;
                end
            end else if (!scl && psc) begin
                if (bitc >= 0) begin
                    if (hrun < hi_min) hi_min = hrun;
                    if (hrun > hi_max) hi_max = hrun;
                end
                bitc++;
                if (bitc == 8) slow = txm ? 1'b0 : !nak;
                else if (bitc == 9) begin
                    bitc = 0; slow = 0;
                    if (goingtx) begin
                        goingtx = 0; txm = 1; k = 0; txb = rdv(0); slow = !txb[7];
                    end else if (txm) begin
                        if (macked) begin k++; txb = rdv(k); slow = !txb[7]; end
                        else txm = 0;
                    end
                end else if (bitc > 0 && bitc < 8 && txm) slow = !txb[7 - bitc];
            end
            psc = scl;
            psd = sda_bus;
        end
    end

    // ---------------- serial reply monitor ----------------
    int urlog [0:63];
    int urn = 0;
    initial begin
        forever begin : mon
            logic [9:0] f;
            @(negedge clk);
            if (!rst && txd === 1'b0) begin
                repeat (CPB / 2) @(negedge clk);
                for (int i = 0; i < 10; i++) begin
                    repeat (CPB) @(negedge clk);
                    f[i] = txd;
                end
                if (urn < 64) urlog[urn] = (f[9] && (^f[8:0]) == 1'b0) ?
                                           {24'b0, f[7:0]} : (32'h1000 | {24'b0, f[7:0]});
                urn++;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    int exp_ev [0:31];
    int exp_ur [0:15];
    int expn = 0, uexpn = 0, ev_base = 0, ur_base = 0;

    task automatic ser(input logic [7:0] b, input bit badp = 0, input bit bads = 0);
        logic [10:0] f;
        f = {~bads, (^b) ^ badp, b, 1'b0};
        for (int i = 0; i < 11; i++) begin
            @(negedge clk) rxd = f[i];
            repeat (CPB - 1) @(negedge clk);
        end
        @(negedge clk) rxd = 1'b1;
        repeat (2 * CPB) @(negedge clk);
    endtask

    task automatic begin_test();
        ev_base = evn; ur_base = urn; expn = 0; uexpn = 0;
    endtask

    task automatic pe(input int v); exp_ev[expn] = v; expn++; endtask
    task automatic pu(input int v); exp_ur[uexpn] = v; uexpn++; endtask

    task automatic end_test(input string req);
        repeat (3000) @(negedge clk);
        chk(evn - ev_base == expn, {req, " bus event count"}, evn - ev_base, expn);
        for (int i = 0; i < expn; i++)
            if (ev_base + i < evn)
                chk(evlog[ev_base + i] == exp_ev[i], {req, " bus event"}, evlog[ev_base + i], exp_ev[i]);
        chk(urn - ur_base == uexpn, {req, " reply count"}, urn - ur_base, uexpn);
        for (int i = 0; i < uexpn; i++)
            if (ur_base + i < urn)
                chk(urlog[ur_base + i] == exp_ur[i], {req, " reply char R1"}, urlog[ur_base + i], exp_ur[i]);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_r10();
        chk(scl === 1'b1, "R10 scl after reset", int'(scl), 1);
        chk(sda_o === 1'b1, "R10 sda after reset", int'(sda_o), 1);
        chk(txd === 1'b1, "R10 txd after reset", int'(txd), 1);
    endtask

    task automatic t_write_r5();
        begin_test(); cmd_only = 0;
        ser(8'h79); ser(8'h84); ser(8'h10); ser(8'h03); ser(8'h11); ser(8'h22); ser(8'h33);
        pe(32'h100); pe(32'h84); pe(32'h10); pe(32'h11); pe(32'h22); pe(32'h33); pe(32'h101);
        pu(32'hC3);
        end_test("R5 register write");
        chk(scl === 1'b1 && sda_o === 1'b1, "R10 bus idle after STOP", int'({scl, sda_o}), 3);
    endtask

    task automatic t_read_r6();
        begin_test(); cmd_only = 0;
        ser(8'h79); ser(8'hA1); ser(8'h20); ser(8'h02);
        pe(32'h100); pe(32'hA0); pe(32'h20); pe(32'h100); pe(32'hA1);
        pe(32'h200 | rdv(0)); pe(32'h300); pe(32'h200 | rdv(1)); pe(32'h301); pe(32'h101);
        pu(rdv(0)); pu(rdv(1)); pu(32'hC3);
        end_test("R6 register read");
    endtask

    task automatic t_cmd_only_r7();
        begin_test(); cmd_only = 1;
        ser(8'h79); ser(8'h84); ser(8'h55); ser(8'h01); ser(8'h5A);
        pe(32'h100); pe(32'h84); pe(32'h5A); pe(32'h101);
        pu(32'hC3);
        end_test("R7 command-only write");
        begin_test();
        ser(8'h79); ser(8'hA1); ser(8'h55); ser(8'h03);
        pe(32'h100); pe(32'hA1);
        pe(32'h200 | rdv(0)); pe(32'h300); pe(32'h200 | rdv(1)); pe(32'h300);
        pe(32'h200 | rdv(2)); pe(32'h301); pe(32'h101);
        pu(rdv(0)); pu(rdv(1)); pu(rdv(2)); pu(32'hC3);
        end_test("R7 command-only read");
        cmd_only = 0;
    endtask

    task automatic t_nack_r8();
        begin_test(); cmd_only = 0;
        nack_at = wcount + 1;
        ser(8'h79); ser(8'h84); ser(8'h30); ser(8'h02); ser(8'h01); ser(8'h02);
        pe(32'h100); pe(32'h84); pe(32'h30); pe(32'h101);
        end_test("R8 refused register byte");
        nack_at = -1;
    endtask

    task automatic t_bad_sync_r2();
        begin_test();
        ser(8'h55); ser(8'h84); ser(8'h10); ser(8'h01); ser(8'h77);
        end_test("R2 missing sync");
    endtask

    task automatic t_frame_err_r3();
        begin_test();
        ser(8'h79); ser(8'h84); ser(8'h10, 1'b1, 1'b0); ser(8'h01); ser(8'h44);
        end_test("R3 parity error");
        begin_test();
        ser(8'h79); ser(8'h84); ser(8'h10); ser(8'h01); ser(8'h44, 1'b0, 1'b1);
        end_test("R3 stop error");
    endtask

    task automatic t_count_r4();
        begin_test();
        ser(8'h79); ser(8'h84); ser(8'h10); ser(8'h00);
        end_test("R4 count zero");
        begin_test();
        ser(8'h79); ser(8'hA1); ser(8'h10); ser(8'(MAXB + 1));
        end_test("R4 count above max");
        begin_test();
        ser(8'h79); ser(8'h84); ser(8'h40); ser(8'(MAXB));
        pe(32'h100); pe(32'h84); pe(32'h40);
        for (int i = 0; i < MAXB; i++) begin
            ser(8'(8'h90 + i));
            pe(32'h90 + i);
        end
        pe(32'h101); pu(32'hC3);
        end_test("R4 count at max");
    endtask

    task automatic t_timing_r9();
        chk(hi_min == 2 * QTR, "R9 shortest SCL high", hi_min, 2 * QTR);
        chk(hi_max == 2 * QTR, "R9 longest SCL high", hi_max, 2 * QTR);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset_r10();
        t_write_r5();
        t_read_r6();
        t_cmd_only_r7();
        t_nack_r8();
        t_bad_sync_r2();
        t_frame_err_r3();
        t_count_r4();
        t_write_r5();
        t_timing_r9();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule